// File: doc/BRIEF.md
# 32-bit Integer ALU with Signed-Correct Compare

This block is the combinational arithmetic logic unit of a simple load/store processor datapath. Two 32-bit operands and a 4-bit operation selector go in. A 32-bit result, a zero flag and a signed overflow flag come out in the same cycle. No register sits inside the block.

The supported operations are bitwise AND, OR and NOR, plus add, subtract and signed set-on-less-than. One adder serves all three arithmetic operations. For subtract and compare, the second operand is inverted and the carry-in is forced to 1. The compare takes the sign of the difference and XORs it with the signed overflow of that subtraction. This keeps the answer correct when the difference wraps.

Top module: `alu32`

## Requirements
- R1: Selector 4'b0000 gives the bitwise AND of the two operands.
- R2: Selector 4'b0001 gives the bitwise OR of the two operands.
- R3: Selector 4'b0011 gives the sum of the operands modulo 2^32. The overflow flag is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R4: Selector 4'b0110 gives the first operand minus the second, modulo 2^32. The overflow flag is 1 exactly when the operand sign bits differ and the result's sign bit differs from the first operand's sign bit.
- R5: Selector 4'b1100 gives the bitwise NOR of the two operands.
- R6: Selector 4'b0111 gives bit 0 = 1 when the first operand is less than the second as two's-complement numbers, including when the subtraction overflows. Bits 31 to 1 of the result are 0.
- R7: Under selector 4'b0111, the overflow flag reports the signed overflow of the first operand minus the second, by the same rule as R4.
- R8: The zero flag is 1 exactly when all 32 result bits are 0, for every selector.
- R9: Any selector other than the six above gives a result of 0 and an overflow flag of 0. By R8 the zero flag is then 1.
- R10: For the AND, OR and NOR selectors the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation selector |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add, subtract or compare |

## Verification
The block holds no state. A wrong carry, a wrong inversion or a wrong selector decode shows at the ports in the same cycle as the input that exposes it.

The failure that is easiest to miss is an uncorrected compare. It gives the right answer for every pair whose difference does not wrap. It goes wrong only for operands of opposite sign and large magnitude. For this reason the corner operands include the most negative value, the most positive value, 0, 1 and all ones, and every pair of them is applied under all 16 selectors.

// File: rtl/alu32.sv
module alu32 #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         ovf
);
  localparam logic [3:0] SEL_AND = 4'b0000;
  localparam logic [3:0] SEL_OR  = 4'b0001;
  localparam logic [3:0] SEL_ADD = 4'b0011;
  localparam logic [3:0] SEL_SUB = 4'b0110;
  localparam logic [3:0] SEL_SLT = 4'b0111;
  localparam logic [3:0] SEL_NOR = 4'b1100;

  logic         invert_b;
  logic [W-1:0] b_eff;
  logic [W:0]   sum_ext;
  logic [W-1:0] sum;
  logic         carry_out;
  logic         carry_msb;
  logic         v_flag;
  logic         less;

  assign invert_b  = (op_sel == SEL_SUB) || (op_sel == SEL_SLT);
  assign b_eff     = invert_b ? ~op_b : op_b;
  assign sum_ext   = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, invert_b};
  assign sum       = sum_ext[W-1:0];
  assign carry_out = sum_ext[W];
  assign carry_msb = op_a[W-1] ^ b_eff[W-1] ^ sum[W-1];
  assign v_flag    = carry_msb ^ carry_out;
  assign less      = sum[W-1] ^ v_flag;

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op_sel)
      SEL_AND: result = op_a & op_b;
      SEL_OR:  result = op_a | op_b;
      SEL_NOR: result = ~op_a & ~op_b;
      SEL_ADD, SEL_SUB: begin
        result = sum;
        ovf    = v_flag;
      end
      SEL_SLT: begin
        result = {{(W-1){1'b0}}, less};
        ovf    = v_flag;
      end
      default: begin
        result = '0;
        ovf    = 1'b0;
      end
    endcase
  end

  assign zero = ~|result;
endmodule

module alu32_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         ovf
);
  always @* begin
    if (!$isunknown({op_a, op_b, op_sel, result, zero, ovf})) begin
      if (op_sel == 4'b0011)
        a_r3_add_inverse: assert (result - op_b == op_a);
      if (op_sel == 4'b0110)
        a_r4_sub_inverse: assert (result + op_b == op_a);
      if (op_sel == 4'b0111)
        a_r6_slt_signed: assert (result == {{(W-1){1'b0}}, ($signed(op_a) < $signed(op_b))});
      if (op_sel == 4'b0000 || op_sel == 4'b0001 || op_sel == 4'b1100)
        a_r10_logic_no_ovf: assert (!ovf);
      if (!(op_sel inside {4'b0000, 4'b0001, 4'b0011, 4'b0110, 4'b0111, 4'b1100}))
        a_r9_undef_quiet: assert (result == '0 && !ovf && zero);
    end
  end
endmodule

bind alu32 alu32_chk #(.W(W)) u_alu32_chk (
  .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
  .result(result), .zero(zero), .ovf(ovf)
);

// File: tb/alu32_bench.sv
module alu32_bench;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  op_sel = '0;
  logic [31:0] result;
  logic        zero;
  logic        ovf;
  int vectors = 0;
  int misses = 0;
  logic [31:0] corners [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0001};

  always #2 clk = ~clk;

  alu32 u_alu32 (.op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result), .zero(zero), .ovf(ovf));

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0011: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R6/R7";
      4'b1100: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] s);
    logic [31:0] er;
    logic        eo;
    logic        ez;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; op_sel = s;
    er = '0; eo = 1'b0;
    case (s)
      4'b0000: er = a & b;
      4'b0001: er = a | b;
      4'b1100: er = ~(a | b);
      4'b0011: begin er = a + b; eo = (a[31] == b[31]) && (er[31] != a[31]); end
      4'b0110: begin er = a - b; eo = (a[31] != b[31]) && (er[31] != a[31]); end
      4'b0111: begin
        er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        eo = (a[31] != b[31]) && (((a - b) >> 31) != {31'd0, a[31]});
      end
      default: begin er = '0; eo = 1'b0; end
    endcase
    ez = (er == 32'd0);
    @(negedge clk);
    vectors++;
    if (result !== er) begin
      misses++;
      $display("FAIL %s result sel=%b a=%h b=%h actual=%h expected=%h", tag_of(s), s, a, b, result, er);
    end
    if (ovf !== eo) begin
      misses++;
      $display("FAIL %s ovf (R7/R10) sel=%b a=%h b=%h actual=%b expected=%b", tag_of(s), s, a, b, ovf, eo);
    end
    if (zero !== ez) begin
      misses++;
      $display("FAIL R8 zero sel=%b a=%h b=%h actual=%b expected=%b", s, a, b, zero, ez);
    end
  endtask

  initial begin
    #(200000 * 4);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // Idle state: zero operands under AND, R8 zero flag high
    apply(32'h0, 32'h0, 4'b0000);
    // R6 compare with overflowing difference
    apply(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
    // R3 / R4 overflow boundaries
    apply(32'h7FFF_FFFF, 32'h1, 4'b0011);
    apply(32'h8000_0000, 32'h1, 4'b0110);
    apply(32'hFFFF_FFFF, 32'h1, 4'b0011);
    // R9 undefined selectors with nonzero operands
    apply(32'hDEAD_BEEF, 32'h1234_5678, 4'b1111);
    apply(32'hDEAD_BEEF, 32'h1234_5678, 4'b0010);
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(corners[i], corners[j], 4'(s));
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] s;
      logic [31:0] a;
      logic [31:0] b;
      s = 4'($urandom_range(0, 15));
      if (k % 2 == 0) s = (k % 12 < 2) ? 4'b0000 : (k % 12 < 4) ? 4'b0001 :
                          (k % 12 < 6) ? 4'b0011 : (k % 12 < 8) ? 4'b0110 :
                          (k % 12 < 10) ? 4'b0111 : 4'b1100;
      a = $urandom;
      b = (k % 7 == 0) ? a : $urandom;
      apply(a, b, s);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule